// File: doc/BRIEF.md
# Banked Status and Register Bank Unit

This block keeps the processor status word and the floating-point status word of a CPU core. Next to them it holds two banks of eight 32-bit integer registers (R0 to R7) and two banks of sixteen 32-bit floating-point registers. Only one bank of each kind is visible to the core. The other bank is a shadow copy. A write to the status word that changes the selected integer bank exchanges the live and shadow integer registers on that same clock edge. A write to the floating-point status word that flips its bank-select bit exchanges all sixteen floating-point pairs in the same way.

The condition flags T, S, Q and M sit in flip-flops of their own, so the datapath can update them without rewriting the whole status word. They are merged back into the word whenever it is read. A combinational debug port reads any register by number. A fixed index range always names integer bank 0 and a second range always names integer bank 1, whichever bank is live at the time.

Every interface here is a plain register-file style port: a write strobe and its data are accepted on the clock edge, and reads are combinational. No stream carries data, so there is no valid/ready handshake and no back-pressure.

Top module: `bsr_bank_unit`

## Requirements
- R1: After reset the status word reads 0x700000F0, the FP status word reads 0x00040001, every integer and FP register is zero, and integer bank 1 is active.
- R2: The active integer bank is 1 only when status bit 30 (privileged) and bit 29 (bank select) are both 1; otherwise it is 0. `active_bank` shows it.
- R3: A status write exchanges the live and shadow R0–R7 only when the active bank computed from the new word differs from the one computed from the old word. A status write that keeps the same active bank leaves every register where it was.
- R4: A status write keeps only the bits in mask 0x700083F3. All other bits read back as zero.
- R5: The flags sit at status bits T=0, S=1, Q=8, M=9. A status write loads them from the written word. When there is no status write, `flag_wr_en` loads them from `flag_wr_val` (bit 0 is T, bit 1 is S, bit 2 is Q, bit 3 is M). A read always shows the current flags at their bit positions.
- R6: An FP status write keeps only the bits in mask 0x003FFFFF. When bit 21 changes value, all sixteen live and shadow FP registers are exchanged.
- R7: Register writes go to the bank that was live before the clock edge. If a swap happens on the same edge, the written value ends up in the shadow bank, together with the rest of that bank.
- R8: Debug index 0–7 reads live R0–R7. Index 22 reads the status word and index 24 reads the FP status word. Index 25–40 reads live FP registers 0–15. Index 43–50 reads bank-0 R0–R7 and index 51–58 reads bank-1 R0–R7, whichever bank is live. Any other index up to 42 returns zero. `dbg_hit` is 1 for every index 0–58.
- R9: For indices 59–127, `dbg_hit` is 0 and `dbg_data` is zero. `dbg_bad_idx` is 1 only for indices above 93.
- R10: `mask_changed` is high for exactly the one cycle after each status write, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | 32 | New status word |
| fp_wr_en | input | 1 | FP status word write strobe |
| fp_wr_data | input | 32 | New FP status word |
| flag_wr_en | input | 1 | Flag-only update strobe |
| flag_wr_val | input | 4 | New flags {M,Q,S,T} |
| gpr_wr_en | input | 1 | Live integer register write strobe |
| gpr_wr_idx | input | 3 | Integer register number |
| gpr_wr_data | input | 32 | Integer write data |
| fpr_wr_en | input | 1 | Live FP register write strobe |
| fpr_wr_idx | input | 4 | FP register number |
| fpr_wr_data | input | 32 | FP write data |
| gpr_rd_idx | input | 3 | Live integer read index |
| gpr_rd_data | output | 32 | Live integer read data |
| fpr_rd_idx | input | 4 | Live FP read index |
| fpr_rd_data | output | 32 | Live FP read data |
| sr_rd_data | output | 32 | Status word with flags merged in |
| fp_rd_data | output | 32 | FP status word |
| active_bank | output | 1 | Active integer bank |
| mask_changed | output | 1 | One-cycle pulse after a status write |
| dbg_idx | input | 7 | Debug register number |
| dbg_data | output | 32 | Debug read data |
| dbg_hit | output | 1 | Index names a held register (0–58) |
| dbg_bad_idx | output | 1 | Index lies beyond 93 |

## Verification
Status words are written in three ways: so the privileged and bank-select bits move together, so only one of them moves, and so neither moves. These cases show a real bank exchange apart from a write that only looks like one. A status write is also placed on the same cycle as an integer register write, to show which bank receives the data. Debug reads sweep the whole 0–127 index range under both active banks, which shows the absolute bank-0 and bank-1 mapping apart from the live-register mapping. A long pseudo-random stretch then mixes all the write ports against a reference model that stores each bank by its absolute number.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int XLEN = 32;
  localparam int GPR_N = 8;
  localparam int FPR_N = 16;
  localparam int DBG_W = 7;

  localparam logic [XLEN-1:0] SR_KEEP   = 32'h7000_83F3;
  localparam logic [XLEN-1:0] SR_INIT   = 32'h7000_00F0;
  localparam logic [XLEN-1:0] FPS_KEEP  = 32'h003F_FFFF;
  localparam logic [XLEN-1:0] FPS_INIT  = 32'h0004_0001;

  localparam int SR_PRIV = 30;
  localparam int SR_BSEL = 29;
  localparam int SR_T = 0;
  localparam int SR_S = 1;
  localparam int SR_Q = 8;
  localparam int SR_M = 9;
  localparam int FPS_BSEL = 21;

  localparam logic [XLEN-1:0] FLAG_BITS =
    (32'h1 << SR_T) | (32'h1 << SR_S) | (32'h1 << SR_Q) | (32'h1 << SR_M);

  typedef struct packed {
    logic m;
    logic q;
    logic s;
    logic t;
  } flags_t;

  function automatic logic bank_of(input logic [XLEN-1:0] w);
    return w[SR_PRIV] & w[SR_BSEL];
  endfunction
endpackage

// File: rtl/bsr_bank_pair.sv
module bsr_bank_pair #(
  parameter int N = 8,
  parameter int W = 32,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [W-1:0]      wr_data,
  input  logic              swap,
  output logic [N-1:0][W-1:0] live_o,
  output logic [N-1:0][W-1:0] shadow_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [W-1:0] live_nx;
    always_comb begin
      live_nx = live_o[i];
      if (wr_en && (wr_idx == IW'(i))) live_nx = wr_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_o[i]   <= '0;
        shadow_o[i] <= '0;
      end else if (swap) begin
        live_o[i]   <= shadow_o[i];
        shadow_o[i] <= live_nx;
      end else begin
        live_o[i]   <= live_nx;
      end
    end
  end
endmodule

// File: rtl/bsr_status.sv
module bsr_status
  import bsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_wr_en,
  input  logic [XLEN-1:0] sr_wr_data,
  input  logic            fp_wr_en,
  input  logic [XLEN-1:0] fp_wr_data,
  input  logic            flag_wr_en,
  input  logic [3:0]      flag_wr_val,
  output logic [XLEN-1:0] sr_rd,
  output logic [XLEN-1:0] fp_rd,
  output logic            bank_cur,
  output logic            gpr_swap,
  output logic            fpr_swap,
  output logic            mask_chg
);
  logic [XLEN-1:0] sr_q;
  logic [XLEN-1:0] fp_q;
  flags_t          fl_q;

  assign bank_cur = bank_of(sr_q);
  assign gpr_swap = sr_wr_en && (bank_of(sr_wr_data) != bank_cur);
  assign fpr_swap = fp_wr_en && (fp_wr_data[FPS_BSEL] != fp_q[FPS_BSEL]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= SR_INIT & ~FLAG_BITS;
      fl_q     <= flags_t'({SR_INIT[SR_M], SR_INIT[SR_Q], SR_INIT[SR_S], SR_INIT[SR_T]});
      fp_q     <= FPS_INIT;
      mask_chg <= 1'b0;
    end else begin
      mask_chg <= sr_wr_en;
      if (sr_wr_en) begin
        sr_q <= sr_wr_data & SR_KEEP & ~FLAG_BITS;
        fl_q <= flags_t'({sr_wr_data[SR_M], sr_wr_data[SR_Q],
                          sr_wr_data[SR_S], sr_wr_data[SR_T]});
      end else if (flag_wr_en) begin
        fl_q <= flags_t'(flag_wr_val);
      end
      if (fp_wr_en) fp_q <= fp_wr_data & FPS_KEEP;
    end
  end

  always_comb begin
    sr_rd = sr_q & ~FLAG_BITS;
    sr_rd[SR_T] = fl_q.t;
    sr_rd[SR_S] = fl_q.s;
    sr_rd[SR_Q] = fl_q.q;
    sr_rd[SR_M] = fl_q.m;
  end
  assign fp_rd = fp_q;
endmodule

// File: rtl/bsr_debug_mux.sv
module bsr_debug_mux
  import bsr_pkg::*;
(
  input  logic [DBG_W-1:0]            idx,
  input  logic [GPR_N-1:0][XLEN-1:0]  g_live,
  input  logic [GPR_N-1:0][XLEN-1:0]  g_shadow,
  input  logic [FPR_N-1:0][XLEN-1:0]  f_live,
  input  logic                        bank,
  input  logic [XLEN-1:0]             sr,
  input  logic [XLEN-1:0]             fps,
  output logic [XLEN-1:0]             data,
  output logic                        hit,
  output logic                        bad
);
  localparam int LIVE_G0 = 0;
  localparam int SR_IDX  = 22;
  localparam int FPS_IDX = 24;
  localparam int LIVE_F0 = 25;
  localparam int ABS_B0  = 43;
  localparam int ABS_B1  = ABS_B0 + GPR_N;
  localparam int TOP_OK  = ABS_B1 + GPR_N;
  localparam int TOP_ANY = 94;

  logic [DBG_W-1:0] off_f, off_b0, off_b1;
  assign off_f  = idx - DBG_W'(LIVE_F0);
  assign off_b0 = idx - DBG_W'(ABS_B0);
  assign off_b1 = idx - DBG_W'(ABS_B1);

  assign hit = idx < DBG_W'(TOP_OK);
  assign bad = idx >= DBG_W'(TOP_ANY);

  always_comb begin
    data = '0;
    if (idx < DBG_W'(LIVE_G0 + GPR_N))
      data = g_live[idx[2:0]];
    else if (idx == DBG_W'(SR_IDX))
      data = sr;
    else if (idx == DBG_W'(FPS_IDX))
      data = fps;
    else if (idx >= DBG_W'(LIVE_F0) && idx < DBG_W'(LIVE_F0 + FPR_N))
      data = f_live[off_f[3:0]];
    else if (idx >= DBG_W'(ABS_B0) && idx < DBG_W'(ABS_B1))
      data = bank ? g_shadow[off_b0[2:0]] : g_live[off_b0[2:0]];
    else if (idx >= DBG_W'(ABS_B1) && idx < DBG_W'(TOP_OK))
      data = bank ? g_live[off_b1[2:0]] : g_shadow[off_b1[2:0]];
  end
endmodule

// File: rtl/bsr_bank_unit.sv
module bsr_bank_unit
  import bsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_wr_en,
  input  logic [31:0]      sr_wr_data,
  input  logic             fp_wr_en,
  input  logic [31:0]      fp_wr_data,
  input  logic             flag_wr_en,
  input  logic [3:0]       flag_wr_val,
  input  logic             gpr_wr_en,
  input  logic [2:0]       gpr_wr_idx,
  input  logic [31:0]      gpr_wr_data,
  input  logic             fpr_wr_en,
  input  logic [3:0]       fpr_wr_idx,
  input  logic [31:0]      fpr_wr_data,
  input  logic [2:0]       gpr_rd_idx,
  output logic [31:0]      gpr_rd_data,
  input  logic [3:0]       fpr_rd_idx,
  output logic [31:0]      fpr_rd_data,
  output logic [31:0]      sr_rd_data,
  output logic [31:0]      fp_rd_data,
  output logic             active_bank,
  output logic             mask_changed,
  input  logic [6:0]       dbg_idx,
  output logic [31:0]      dbg_data,
  output logic             dbg_hit,
  output logic             dbg_bad_idx
);
  logic gpr_swap, fpr_swap;
  logic [GPR_N-1:0][XLEN-1:0] g_live, g_shadow;
  logic [FPR_N-1:0][XLEN-1:0] f_live, f_shadow;

  bsr_status u_status (
    .clk, .rst_n,
    .sr_wr_en, .sr_wr_data, .fp_wr_en, .fp_wr_data,
    .flag_wr_en, .flag_wr_val,
    .sr_rd(sr_rd_data), .fp_rd(fp_rd_data),
    .bank_cur(active_bank), .gpr_swap, .fpr_swap,
    .mask_chg(mask_changed)
  );

  bsr_bank_pair #(.N(GPR_N), .W(XLEN)) u_gpr (
    .clk, .rst_n,
    .wr_en(gpr_wr_en), .wr_idx(gpr_wr_idx), .wr_data(gpr_wr_data),
    .swap(gpr_swap), .live_o(g_live), .shadow_o(g_shadow)
  );

  bsr_bank_pair #(.N(FPR_N), .W(XLEN)) u_fpr (
    .clk, .rst_n,
    .wr_en(fpr_wr_en), .wr_idx(fpr_wr_idx), .wr_data(fpr_wr_data),
    .swap(fpr_swap), .live_o(f_live), .shadow_o(f_shadow)
  );

  assign gpr_rd_data = g_live[gpr_rd_idx];
  assign fpr_rd_data = f_live[fpr_rd_idx];

  bsr_debug_mux u_dbg (
    .idx(dbg_idx), .g_live, .g_shadow, .f_live,
    .bank(active_bank), .sr(sr_rd_data), .fps(fp_rd_data),
    .data(dbg_data), .hit(dbg_hit), .bad(dbg_bad_idx)
  );
endmodule

// File: rtl/bsr_bank_unit_chk.sv
module bsr_bank_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sr_wr_en,
  input logic        flag_wr_en,
  input logic [3:0]  flag_wr_val,
  input logic [31:0] sr_rd_data,
  input logic [31:0] fp_rd_data,
  input logic        active_bank,
  input logic        mask_changed,
  input logic [6:0]  dbg_idx,
  input logic        dbg_hit,
  input logic        dbg_bad_idx
);
  AST_SR_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd_data & ~32'h7000_83F3) == 32'h0); // R4

  AST_FPS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_rd_data & ~32'h003F_FFFF) == 32'h0); // R6

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_en |=> $stable(active_bank)); // R3

  AST_MASK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en |=> mask_changed); // R10

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_en |=> !mask_changed); // R10

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && !sr_wr_en) |=> (sr_rd_data[0] == $past(flag_wr_val[0]))); // R5

  AST_DBG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_idx > 7'd93) |-> (dbg_bad_idx && !dbg_hit)); // R9
endmodule

bind bsr_bank_unit bsr_bank_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .flag_wr_en(flag_wr_en),
  .flag_wr_val(flag_wr_val), .sr_rd_data(sr_rd_data), .fp_rd_data(fp_rd_data),
  .active_bank(active_bank), .mask_changed(mask_changed), .dbg_idx(dbg_idx),
  .dbg_hit(dbg_hit), .dbg_bad_idx(dbg_bad_idx)
);

// File: tb/bsr_bank_unit_tb_top.sv
module bsr_bank_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_wr_en = 0, fp_wr_en = 0, flag_wr_en = 0, gpr_wr_en = 0, fpr_wr_en = 0;
  logic [31:0] sr_wr_data = 0, fp_wr_data = 0, gpr_wr_data = 0, fpr_wr_data = 0;
  logic [3:0] flag_wr_val = 0, fpr_wr_idx = 0, fpr_rd_idx = 0;
  logic [2:0] gpr_wr_idx = 0, gpr_rd_idx = 0;
  logic [6:0] dbg_idx = 0;
  logic [31:0] gpr_rd_data, fpr_rd_data, sr_rd_data, fp_rd_data, dbg_data;
  logic active_bank, mask_changed, dbg_hit, dbg_bad_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state, banks stored by absolute number
  logic [31:0] g [2][8];
  logic [31:0] f [2][16];
  logic [31:0] m_sr, m_fp;
  logic [3:0]  m_fl;   // {M,Q,S,T}
  logic        m_mc;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsr_bank_unit dut_i (.*);

  function automatic logic m_bank();
    return m_sr[30] & m_sr[29];
  endfunction

  function automatic logic [31:0] m_srrd();
    logic [31:0] w;
    w = m_sr;
    w[0] = m_fl[0]; w[1] = m_fl[1]; w[8] = m_fl[2]; w[9] = m_fl[3];
    return w;
  endfunction

  function automatic logic [31:0] m_dbg(input int i);
    if (i < 8) return g[m_bank()][i];
    if (i == 22) return m_srrd();
    if (i == 24) return m_fp;
    if (i >= 25 && i <= 40) return f[m_fp[21]][i-25];
    if (i >= 43 && i <= 50) return g[0][i-43];
    if (i >= 51 && i <= 58) return g[1][i-51];
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1/R4/R5 sr", sr_rd_data, m_srrd());
    chk("R1/R6 fpscr", fp_rd_data, m_fp);
    chk("R2 bank", {31'h0, active_bank}, {31'h0, m_bank()});
    chk("R3/R7 gpr", gpr_rd_data, g[m_bank()][gpr_rd_idx]);
    chk("R6/R7 fpr", fpr_rd_data, f[m_fp[21]][fpr_rd_idx]);
    chk("R10 mask", {31'h0, mask_changed}, {31'h0, m_mc});
    chk("R8/R9 dbg data", dbg_data, m_dbg(int'(dbg_idx)));
    chk("R8/R9 dbg hit", {31'h0, dbg_hit}, {31'h0, dbg_idx < 7'd59});
    chk("R9 dbg bad", {31'h0, dbg_bad_idx}, {31'h0, dbg_idx > 7'd93});
  endtask

  // one clock: inputs already set at negedge; compare, then update model past the edge
  task automatic step();
    logic ob;
    #1 compare_all();
    @(posedge clk);
    ob = m_bank();
    if (gpr_wr_en) g[ob][gpr_wr_idx] = gpr_wr_data;
    if (fpr_wr_en) f[m_fp[21]][fpr_wr_idx] = fpr_wr_data;
    if (sr_wr_en) begin
      m_sr = sr_wr_data & 32'h7000_83F3 & ~32'h0000_0303;
      m_fl = {sr_wr_data[9], sr_wr_data[8], sr_wr_data[1], sr_wr_data[0]};
    end else if (flag_wr_en) m_fl = flag_wr_val;
    if (fp_wr_en) m_fp = fp_wr_data & 32'h003F_FFFF;
    m_mc = sr_wr_en;
    @(negedge clk);
    {sr_wr_en, fp_wr_en, flag_wr_en, gpr_wr_en, fpr_wr_en} = '0;
  endtask

  task automatic wsr(input logic [31:0] d);
    sr_wr_en = 1; sr_wr_data = d; step();
  endtask
  task automatic wg(input int i, input logic [31:0] d);
    gpr_wr_en = 1; gpr_wr_idx = 3'(i); gpr_wr_data = d; step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 8; i++) g[b][i] = 0;
      for (int i = 0; i < 16; i++) f[b][i] = 0;
    end
    m_sr = 32'h7000_00F0; m_fl = 4'h0; m_fp = 32'h0004_0001; m_mc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, explicit constants
    #1;
    chk("R1 sr reset", sr_rd_data, 32'h7000_00F0);
    chk("R1 fp reset", fp_rd_data, 32'h0004_0001);
    chk("R1 bank reset", {31'h0, active_bank}, 32'h1);
    step();
    // fill live bank 1
    for (int i = 0; i < 8; i++) wg(i, 32'h1100_0000 + i);
    // R3 bank change: MD=0 -> bank 0; live becomes old shadow (zeros)
    wsr(32'h2000_0000);
    gpr_rd_idx = 3; step();
    chk("R3 swap to bank0 live", gpr_rd_data, 32'h0);
    for (int i = 0; i < 8; i++) wg(i, 32'h0B00_0000 + i);
    // R3 no swap: RB toggles while MD=0 (bank stays 0)
    wsr(32'h0000_0000);
    gpr_rd_idx = 5; step();
    chk("R3 no swap", gpr_rd_data, 32'h0B00_0005);
    // R8 absolute debug views
    dbg_idx = 7'd45; step();
    chk("R8 dbg bank0 R2", dbg_data, 32'h0B00_0002);
    dbg_idx = 7'd56; step();
    chk("R8 dbg bank1 R5", dbg_data, 32'h1100_0005);
    // R7 write coinciding with swap lands in old (bank0)
    gpr_wr_en = 1; gpr_wr_idx = 1; gpr_wr_data = 32'hDEAD_0001;
    wsr(32'h7000_0000);
    dbg_idx = 7'd44; gpr_rd_idx = 1; step();
    chk("R7 write to old bank", dbg_data, 32'hDEAD_0001);
    chk("R7 live is bank1", gpr_rd_data, 32'h1100_0001);
    // R4 mask, R5 flags
    wsr(32'hFFFF_FFFF);
    chk("R4 masked sr", sr_rd_data, 32'h7000_83F3);
    flag_wr_en = 1; flag_wr_val = 4'b0101; step();
    chk("R5 flag port", sr_rd_data, 32'h7000_80F1 | 32'h100);
    // R6 FP swap
    fpr_wr_en = 1; fpr_wr_idx = 7; fpr_wr_data = 32'hF00D_0007; step();
    fp_wr_en = 1; fp_wr_data = 32'hFFFF_FFFF; step();
    chk("R6 fp mask", fp_rd_data, 32'h003F_FFFF);
    fpr_rd_idx = 7; dbg_idx = 7'd32; step();
    chk("R6 fp swapped", fpr_rd_data, 32'h0);
    fp_wr_en = 1; fp_wr_data = 32'h0020_0000; step();
    chk("R6 same FR no swap", fpr_rd_data, 32'h0);
    // R9 range sweep under both banks
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 128; i++) begin dbg_idx = 7'(i); step(); end
      wsr(b == 0 ? 32'h0 : 32'h6000_0000);
    end
    // pseudo-random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      sr_wr_en = (r[2:0] == 0); sr_wr_data = $urandom;
      fp_wr_en = (r[5:3] == 0); fp_wr_data = $urandom;
      flag_wr_en = r[6]; flag_wr_val = r[10:7];
      gpr_wr_en = r[11]; gpr_wr_idx = r[14:12]; gpr_wr_data = $urandom;
      fpr_wr_en = r[15]; fpr_wr_idx = r[19:16]; fpr_wr_data = $urandom;
      gpr_rd_idx = r[22:20]; fpr_rd_idx = r[26:23]; dbg_idx = 7'($urandom);
      step();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule